// File: doc/BRIEF.md
# Outer Bank Extension from CHR Bank Registers

On cartridge boards that carry only 8 KB of CHR RAM, the upper bits of the two CHR bank registers have no CHR address lines to drive. This block gives those spare bits other work. A chosen bit can act as the top bit of the PRG ROM bank (a 256 KB outer bank), two bits can choose one of four 8 KB PRG RAM pages, or one bit can shut PRG RAM off. A board-type input picks which of these jobs are wired. The serial loading of the registers happens elsewhere; this block only takes the register values the mapper already holds.

Which CHR register supplies the spare bits depends on the CHR mode. In 8 KB mode only the first register counts. In 4 KB mode the register is picked from the PPU A12 level latched at the most recent PPU address strobe. As a result, the PRG ROM outer bit, the RAM page and the RAM enable can change while the PPU renders. When PRG RAM is shut off, the chip enable and the data output enable both drop, so the CPU data bus floats.

Top module: `outer_bank_ext`

## Requirements
- R1: After reset the latched A12 level is 0, so in 4 KB mode the first CHR register (`chr_bank0`) is the active one until the first PPU address strobe.
- R2: On each clock edge with `ppu_addr_stb` high, the latched A12 level takes the value of `ppu_a12`. Without a strobe it holds. In 4 KB mode the active register is `chr_bank1` when the latch is 1 and `chr_bank0` when it is 0, and outputs follow from the cycle after the strobe edge.
- R3: When `chr_4k_mode` is 0 (8 KB mode), the active register is always `chr_bank0`, whatever `chr_bank1` or the latched A12 level hold.
- R4: On board type 4 (full) and board type 2 (outer only), `prg_rom_bank` is {bit 4 of the active register, `prg_inner_bank`}. This holds for every inner bank value, including the value the mapper uses for its fixed bank.
- R5: On board type 4 (full), `ram_bank` equals bits 3:2 of the active register.
- R6: `chr_half` is bit 0 of the active register in 4 KB mode, and the latched A12 level in 8 KB mode.
- R7: On board type 1 (RAM off), PRG RAM is enabled only when both bit 4 of the active register and `prg_ram_off` are 0. On this board type the outer bit and `ram_bank` are 0.
- R8: On board type 2 (outer only), bits 3:2 have no effect and `ram_bank` is 0. On every board type other than 1, bit 4 cannot disable RAM.
- R9: On board type 3 (upper RAM bit only), `ram_bank` is {bit 3 of the active register, 0}. Bit 4 and bit 2 have no effect, and the outer bit is 0.
- R10: On board type 0 (plain) and the unused codes 5 to 7, the outer bit is 0, `ram_bank` is 0, and RAM is enabled exactly when `prg_ram_off` is 0.
- R11: `ram_ce` is high when RAM is enabled and `cpu_ram_sel` is high. `ram_dout_oe` is high only when `ram_ce` and `cpu_read` are both high, and it is low whenever RAM is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chr_bank0 | input | 5 | First CHR bank register value |
| chr_bank1 | input | 5 | Second CHR bank register value |
| chr_4k_mode | input | 1 | 1: two 4 KB CHR banks, 0: one 8 KB bank |
| ppu_a12 | input | 1 | PPU address bit 12 (pattern table half) |
| ppu_addr_stb | input | 1 | A new PPU address is present this cycle |
| prg_ram_off | input | 1 | RAM disable bit from the PRG bank register |
| board_sel | input | 3 | Board type: 0 plain, 1 RAM off, 2 outer only, 3 upper RAM bit, 4 full |
| prg_inner_bank | input | 4 | 16 KB PRG bank number resolved by the mapper, fixed banks included |
| cpu_ram_sel | input | 1 | CPU is addressing the PRG RAM window |
| cpu_read | input | 1 | CPU access is a read |
| prg_rom_bank | output | 5 | Full 16 KB PRG ROM bank number, outer bit on top |
| ram_bank | output | 2 | 8 KB PRG RAM page |
| ram_ce | output | 1 | PRG RAM chip enable |
| ram_dout_oe | output | 1 | RAM drives the CPU data bus |
| chr_half | output | 1 | 4 KB CHR RAM half select |

## Verification
Two events can land on one clock edge: a PPU address strobe that moves the latched A12 level, and a CPU read of PRG RAM whose enable depends on bit 4 of whichever register that strobe selects. The bench sets up the RAM-off board with a clear bit 4 in one register and a set bit 4 in the other, keeps a CPU RAM read active, and fires the strobe with the opposite A12 level. It checks that the data output enable keeps its old value just before the edge and takes the new register's verdict right after it, in both directions.

// File: rtl/obx_pkg.sv
package obx_pkg;

  typedef enum logic [2:0] {
    BRD_PLAIN  = 3'd0,
    BRD_RAMOFF = 3'd1,
    BRD_OUTER  = 3'd2,
    BRD_RAMHI  = 3'd3,
    BRD_FULL   = 3'd4
  } board_e;

  // Does this board route the top spare bit to the PRG ROM outer bank line?
  function automatic logic board_has_outer(board_e b);
    return (b == BRD_FULL) || (b == BRD_OUTER);
  endfunction

  // Is RAM page bit k wired on this board (top = index of the highest page bit)?
  function automatic logic board_has_page_bit(board_e b, int k, int top);
    return (b == BRD_FULL) || ((b == BRD_RAMHI) && (k == top));
  endfunction

  // RAM is reachable when the PRG-register disable is clear and,
  // on the RAM-off board, the spare top bit is clear too.
  function automatic logic ram_allowed(board_e b, logic spare_hi, logic prg_off);
    return !prg_off && !((b == BRD_RAMOFF) && spare_hi);
  endfunction

endpackage

// File: rtl/obx_a12_track.sv
module obx_a12_track (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_stb,
  input  logic a12_in,
  output logic a12_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)        a12_q <= 1'b0;
    else if (addr_stb) a12_q <= a12_in;
  end

  AST_A12_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb |=> (a12_q == $past(a12_in)));   // R2
  AST_A12_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_stb |=> $stable(a12_q));            // R2

endmodule

// File: rtl/obx_reg_pick.sv
module obx_reg_pick #(
  parameter int CHR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_4k,
  input  logic             a12_q,
  input  logic [CHR_W-1:0] bank0,
  input  logic [CHR_W-1:0] bank1,
  output logic [CHR_W-1:0] active,
  output logic             use_upper
);

  assign use_upper = mode_4k && a12_q;

  for (genvar i = 0; i < CHR_W; i++) begin : g_bit
    assign active[i] = use_upper ? bank1[i] : bank0[i];
  end

  AST_8K_FIRST_REG: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_4k |-> (active == bank0));          // R3

endmodule

// File: rtl/obx_field_decode.sv
module obx_field_decode
  import obx_pkg::*;
#(
  parameter int RAM_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       board_code,
  input  logic             spare_hi,
  input  logic [RAM_W-1:0] spare_page,
  input  logic             prg_off,
  output logic             outer_bit,
  output logic [RAM_W-1:0] page,
  output logic             ram_ok
);

  localparam int PAGE_TOP = RAM_W - 1;

  board_e brd;
  assign brd = board_e'(board_code);

  assign outer_bit = board_has_outer(brd) && spare_hi;
  assign ram_ok    = ram_allowed(brd, spare_hi, prg_off);

  for (genvar k = 0; k < RAM_W; k++) begin : g_page
    assign page[k] = board_has_page_bit(brd, k, PAGE_TOP) && spare_page[k];
  end

  AST_PLAIN_NO_OUTER: assert property (@(posedge clk) disable iff (!rst_n)
    (board_code == 3'd0) |-> (!outer_bit && page == '0));   // R10
  AST_RAMHI_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (board_code == 3'd3) |-> (!page[0] && !outer_bit));      // R9
  AST_OUTER_NO_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (board_code == 3'd2) |-> (page == '0));                  // R8

endmodule

// File: rtl/outer_bank_ext.sv
module outer_bank_ext #(
  parameter int CHR_W   = 5,
  parameter int INNER_W = 4,
  parameter int RAM_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CHR_W-1:0]   chr_bank0,
  input  logic [CHR_W-1:0]   chr_bank1,
  input  logic               chr_4k_mode,
  input  logic               ppu_a12,
  input  logic               ppu_addr_stb,
  input  logic               prg_ram_off,
  input  logic [2:0]         board_sel,
  input  logic [INNER_W-1:0] prg_inner_bank,
  input  logic               cpu_ram_sel,
  input  logic               cpu_read,
  output logic [INNER_W:0]   prg_rom_bank,
  output logic [RAM_W-1:0]   ram_bank,
  output logic               ram_ce,
  output logic               ram_dout_oe,
  output logic               chr_half
);

  localparam int HI_POS  = CHR_W - 1;
  localparam int PAGE_LO = HI_POS - RAM_W;

  logic             a12_q;
  logic [CHR_W-1:0] active;
  logic             use_upper;
  logic             outer_bit;
  logic             ram_ok;
  logic             unused_mid;

  obx_a12_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_stb (ppu_addr_stb),
    .a12_in   (ppu_a12),
    .a12_q    (a12_q)
  );

  obx_reg_pick #(.CHR_W(CHR_W)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_4k   (chr_4k_mode),
    .a12_q     (a12_q),
    .bank0     (chr_bank0),
    .bank1     (chr_bank1),
    .active    (active),
    .use_upper (use_upper)
  );

  obx_field_decode #(.RAM_W(RAM_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .board_code (board_sel),
    .spare_hi   (active[HI_POS]),
    .spare_page (active[PAGE_LO +: RAM_W]),
    .prg_off    (prg_ram_off),
    .outer_bit  (outer_bit),
    .page       (ram_bank),
    .ram_ok     (ram_ok)
  );

  assign unused_mid = ^{active[PAGE_LO-1:1], use_upper};

  assign prg_rom_bank = {outer_bit, prg_inner_bank};
  assign chr_half     = chr_4k_mode ? active[0] : a12_q;
  assign ram_ce       = ram_ok && cpu_ram_sel;
  assign ram_dout_oe  = ram_ce && cpu_read;

  AST_FLOAT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    prg_ram_off |-> (!ram_dout_oe && !ram_ce));               // R11
  AST_RAMOFF_BIT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (board_sel == 3'd1 && active[HI_POS]) |-> !ram_dout_oe);  // R7
  AST_INNER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    prg_rom_bank[INNER_W-1:0] == prg_inner_bank);             // R4

endmodule

// File: tb/tb_outer_bank_ext.sv
`timescale 1ns/1ps
module tb_outer_bank_ext;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] b0, b1;
  logic       m4k, a12, stb, roff;
  logic [2:0] brd;
  logic [3:0] inner;
  logic       rsel, rd;
  logic [4:0] rom;
  logic [1:0] page;
  logic       ce, oe, half;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  outer_bank_ext dut (
    .clk(clk), .rst_n(rst_n), .chr_bank0(b0), .chr_bank1(b1),
    .chr_4k_mode(m4k), .ppu_a12(a12), .ppu_addr_stb(stb),
    .prg_ram_off(roff), .board_sel(brd), .prg_inner_bank(inner),
    .cpu_ram_sel(rsel), .cpu_read(rd), .prg_rom_bank(rom),
    .ram_bank(page), .ram_ce(ce), .ram_dout_oe(oe), .chr_half(half)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {board, 4k, bank0, bank1, a12, prg_off, exp_outer, exp_page, exp_en}
  localparam int NV = 14;
  localparam logic [19:0] TBL [NV] = '{
    {3'd4, 1'b1, 5'b10000, 5'b01100, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1},
    {3'd4, 1'b1, 5'b10000, 5'b01100, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1},
    {3'd4, 1'b0, 5'b01000, 5'b10100, 1'b1, 1'b0, 1'b0, 2'b10, 1'b1},
    {3'd4, 1'b1, 5'b00100, 5'b10000, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0},
    {3'd1, 1'b1, 5'b00000, 5'b10000, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0},
    {3'd1, 1'b1, 5'b00000, 5'b10000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1},
    {3'd1, 1'b0, 5'b10000, 5'b00000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0},
    {3'd2, 1'b1, 5'b11100, 5'b01100, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1},
    {3'd2, 1'b1, 5'b11100, 5'b01100, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1},
    {3'd3, 1'b1, 5'b11100, 5'b10100, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1},
    {3'd3, 1'b1, 5'b11100, 5'b10100, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1},
    {3'd0, 1'b1, 5'b11111, 5'b11111, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1},
    {3'd7, 1'b0, 5'b11110, 5'b11111, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1},
    {3'd0, 1'b0, 5'b11110, 5'b00000, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0}
  };

  task automatic strobe(input logic lvl);
    @(negedge clk);
    a12 = lvl; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    #1;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; b0 = 5'b10000; b1 = 5'b00000; m4k = 1'b1; a12 = 1'b1;
    stb = 1'b0; roff = 1'b0; brd = 3'd4; inner = 4'hF; rsel = 1'b1; rd = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: latch clear after reset, first register active even with A12 high
    chk("R1 outer after reset", rom[4], 1);
    chk("R4 fixed bank passes inner", rom[3:0], 15);

    // Table walk: R4 R5 R7 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {brd, m4k, b0, b1} = TBL[i][19:6];
      roff  = TBL[i][4];
      inner = 4'(i);
      strobe(TBL[i][5]);
      chk($sformatf("R4/R8/R9/R10 outer v%0d", i), rom[4], TBL[i][3]);
      chk($sformatf("R4 inner v%0d", i), rom[3:0], i);
      chk($sformatf("R5/R9 page v%0d", i), page, TBL[i][2:1]);
      chk($sformatf("R7/R11 oe v%0d", i), oe, TBL[i][0]);
    end

    // R2: no strobe means the latch holds; output changes only after strobe edge
    brd = 3'd4; m4k = 1'b1; roff = 1'b0; b0 = 5'b10000; b1 = 5'b00000;
    strobe(1'b1);
    chk("R2 upper register after strobe", rom[4], 0);
    @(negedge clk); a12 = 1'b0;
    repeat (3) @(negedge clk); #1;
    chk("R2 hold without strobe", rom[4], 0);
    @(negedge clk); stb = 1'b1; #1;
    chk("R2 unchanged before edge", rom[4], 0);
    @(negedge clk); stb = 1'b0; #1;
    chk("R2 lower register after edge", rom[4], 1);

    // R3: 8 KB mode ignores the second register and A12
    m4k = 1'b0; b1 = 5'b11111;
    strobe(1'b1);
    chk("R3 outer from first reg", rom[4], 1);
    chk("R3 page from first reg", page, 0);

    // R6: CHR half select
    m4k = 1'b1; b0 = 5'b00001; b1 = 5'b00000;
    strobe(1'b0);
    chk("R6 4k half from bank0", half, 1);
    strobe(1'b1);
    chk("R6 4k half from bank1", half, 0);
    m4k = 1'b0; #1;
    chk("R6 8k half follows latch", half, 1);
    strobe(1'b0);
    chk("R6 8k half follows latch low", half, 0);

    // R11: chip enable and output enable gating
    brd = 3'd0; roff = 1'b0; rsel = 1'b1; rd = 1'b0; #1;
    chk("R11 write keeps oe low", oe, 0);
    chk("R11 ce on write", ce, 1);
    rsel = 1'b0; rd = 1'b1; #1;
    chk("R11 ce low outside window", ce, 0);
    chk("R11 oe low outside window", oe, 0);
    rsel = 1'b1;

    // R7 + R2 in one cycle: strobe flips active register during a RAM read
    brd = 3'd1; m4k = 1'b1; b0 = 5'b00000; b1 = 5'b10000;
    strobe(1'b0);
    chk("R7 enabled with clear bit", oe, 1);
    @(negedge clk); a12 = 1'b1; stb = 1'b1; #1;
    chk("R7 oe old before edge", oe, 1);
    @(negedge clk); stb = 1'b0; #1;
    chk("R7 oe floats after edge", oe, 0);
    chk("R7 ce off after edge", ce, 0);
    strobe(1'b0);
    chk("R7 oe back on", oe, 1);

    // R8: bit 4 cannot disable RAM on the full board
    brd = 3'd4; b0 = 5'b10000; #1;
    chk("R8 full board bit4 keeps RAM", oe, 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule